// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider

This block divides a fast source clock by one of several fixed ratios. A 3-bit select bus picks an entry from a table of eight ratios, and the table is set by a parameter. Every legal ratio (1, 2, 3, 4, 6, 8, 9, 10, 12, 15) gives a 50% duty output. For odd ratios the block uses a falling-edge copy of the rising-edge phase, which gives half-cycle resolution. A divide-by-1 entry passes the source clock through a gate that only changes while the clock is low.

The block acts on a new select value only after the value is synchronized and has held still. When it acts, it lets the running output period end and then holds the output low for a short quiet window. It then changes the output path and starts the new ratio with a whole high phase. One control pin has a meaning set by a parameter. As an output enable, a low level silences the output at the next period boundary while the counter keeps its grid. As a power-down, a low level parks the divider at the period boundary. On release, the divider restarts through the quiet window.

Top module: `gf_clkdiv`

## Requirements
- R1: Select code k picks the table entry at bits [4k+3:4k] of `RATIO_TABLE`. A legal entry N sets the output period to N source periods.
- R2: For every legal ratio N in steady state, the high phase and the low phase each last N/2 source periods. A half period counts as a unit, so duty is 50% for odd N too.
- R3: A table entry outside {1,2,3,4,6,8,9,10,12,15} runs as divide-by-1. `ratio_bad` is 1 while that entry is active and 0 otherwise.
- R4: The select bus is synchronized and acted on only after it reads the same value on two consecutive source cycles. A select pulse that lasts one source cycle changes nothing: no stretched low and no other phase length.
- R5: Across a ratio change, every high phase is a full high phase of either the old or the new ratio. The running period finishes, and the new ratio begins with a complete high phase.
- R6: No low phase is shorter than half the smaller of the old and new output periods. A low phase may be stretched over many source cycles.
- R7: While reset is asserted, `clk_out` and `ratio_bad` are 0. After release, the output stays low until the synchronizer has settled. It then starts with a full cycle of the selected ratio.
- R8: With `EN_MODE` = 0 (output enable), `en_pin` low makes `clk_out` stay low from the next period boundary. The counter keeps running, so after re-enable the rising edges fall on the same period grid as before.
- R9: With `EN_MODE` = 1 (power-down), `en_pin` low stops the divider at the period boundary with the counter frozen and the output low. After release, the output restarts with a complete high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsel | input | SEL_W | Ratio select code, asynchronous to clk_src |
| en_pin | input | 1 | Output enable or power-down control, active high |
| clk_out | output | 1 | Divided clock |
| ratio_bad | output | 1 | Active table entry is not a legal ratio |

## Verification
The hardest case to reach is a select change that arrives while a previous change is still pending or sitting in the quiet window. In that case the output must still show only whole high phases of the ratios involved. The stimulus gets there with seeded random select codes held for random short intervals, some shorter than one output period of 15. A phase monitor checks every high phase against the set of ratios seen since the last settled point, and every low phase against the smallest of them. Directed cases add a one-cycle select pulse and enable toggles at odd ratios, where the output edges fall on the source clock's falling edge.

// File: rtl/gfd_pkg.sv
package gfd_pkg;

   // Ratio values up to 15 fit in this width.
   localparam int unsigned RW = 4;

   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_RUN  = 2'd1,
      ST_DOWN = 2'd2
   } gfd_state_e;

   localparam int unsigned EN_OE = 0;
   localparam int unsigned EN_PD = 1;

   function automatic logic ratio_legal(input logic [RW-1:0] r);
      case (r)
         4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd9, 4'd10, 4'd12, 4'd15: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // Rising-edge high count: ceil(N/2)
   function automatic logic [RW-1:0] high_len(input logic [RW-1:0] r);
      logic [RW:0] t;
      t = {1'b0, r} + 1'b1;
      return t[RW:1];
   endfunction

endpackage

// File: rtl/gfd_sync.sv
module gfd_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gfd_ctrl.sv
module gfd_ctrl
   import gfd_pkg::*;
#(
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 2,
   parameter int unsigned EN_MODE     = EN_OE,
   parameter logic [(2**SEL_W)*RW-1:0] RATIO_TABLE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_s,
   input  logic             en_s,
   output logic             pos_q,
   output logic [RW-1:0]    act_ratio,
   output logic             ratio_bad,
   output gfd_state_e       state,
   output logic [RW-1:0]    cnt
);

   localparam int unsigned NENT     = 2**SEL_W;
   localparam int unsigned RST_LAST = SYNC_STAGES + HOLD_CYC - 1;
   localparam int unsigned HW       = $clog2(RST_LAST + 1);
   localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYC - 1);
   localparam logic [HW-1:0] RST_END  = HW'(RST_LAST);

   // Per-entry decode of the ratio table
   logic [RW-1:0] ent_ratio [NENT];
   logic          ent_bad   [NENT];

   for (genvar g = 0; g < NENT; g++) begin : g_ent
      localparam logic [RW-1:0] RAW = RATIO_TABLE[g*RW +: RW];
      assign ent_bad[g]   = !ratio_legal(RAW);
      assign ent_ratio[g] = ent_bad[g] ? RW'(1) : RAW;
   end

   // Enable pin meaning picked by parameter
   logic gate_en;
   logic pd_go;
   if (EN_MODE == EN_PD) begin : g_pd
      assign gate_en = 1'b1;
      assign pd_go   = en_s;
   end else begin : g_oe
      assign gate_en = en_s;
      assign pd_go   = 1'b1;
   end

   logic [SEL_W-1:0] sel_prev;
   logic [SEL_W-1:0] act_sel;
   logic [HW-1:0]    hold_cnt;
   logic             first_q;
   logic             gate_q;

   logic             sel_stable;
   logic             want_switch;
   logic [RW-1:0]    cnt_inc;
   logic [RW-1:0]    hi_len;
   logic             wrap;
   logic             hold_done;

   assign sel_stable  = (sel_s == sel_prev);
   assign want_switch = sel_stable && (sel_s != act_sel);
   assign cnt_inc     = cnt + 1'b1;
   assign hi_len      = high_len(act_ratio);
   assign wrap        = (cnt_inc == act_ratio);
   assign hold_done   = (hold_cnt == (first_q ? RST_END : HOLD_END));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_prev  <= '0;
         act_sel   <= '0;
         act_ratio <= RW'(1);
         ratio_bad <= 1'b0;
         state     <= ST_HOLD;
         cnt       <= '0;
         hold_cnt  <= '0;
         first_q   <= 1'b1;
         gate_q    <= 1'b0;
         pos_q     <= 1'b0;
      end else begin
         sel_prev <= sel_s;
         case (state)
            ST_HOLD: begin
               pos_q <= 1'b0;
               if (!hold_done) begin
                  hold_cnt <= hold_cnt + 1'b1;
               end else if (sel_stable && pd_go) begin
                  act_sel   <= sel_s;
                  act_ratio <= ent_ratio[sel_s];
                  ratio_bad <= ent_bad[sel_s];
                  first_q   <= 1'b0;
                  cnt       <= '0;
                  gate_q    <= gate_en;
                  pos_q     <= gate_en;
                  state     <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (wrap) begin
                  cnt <= '0;
                  if (want_switch) begin
                     state    <= ST_HOLD;
                     hold_cnt <= '0;
                     pos_q    <= 1'b0;
                  end else if (!pd_go) begin
                     state <= ST_DOWN;
                     pos_q <= 1'b0;
                  end else begin
                     gate_q <= gate_en;
                     pos_q  <= gate_en;
                  end
               end else begin
                  cnt   <= cnt_inc;
                  pos_q <= gate_q && (cnt_inc < hi_len);
               end
            end
            ST_DOWN: begin
               pos_q <= 1'b0;
               if (pd_go) begin
                  state    <= ST_HOLD;
                  hold_cnt <= '0;
               end
            end
            default: begin
               state <= ST_HOLD;
               pos_q <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/gfd_outstage.sv
module gfd_outstage
   import gfd_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pos_q,
   input  logic [RW-1:0] act_ratio,
   output logic          neg_q,
   output logic          clk_out
);

   logic is_one;
   logic is_odd;

   // Half-cycle delayed copy of the rising-edge phase
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= 1'b0;
      else        neg_q <= pos_q;
   end

   assign is_one = (act_ratio == RW'(1));
   assign is_odd = act_ratio[0];

   always_comb begin
      if (is_one)      clk_out = neg_q & clk;
      else if (is_odd) clk_out = pos_q & neg_q;
      else             clk_out = pos_q;
   end

endmodule

// File: rtl/gf_clkdiv.sv
module gf_clkdiv
   import gfd_pkg::*;
#(
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 2,
   parameter int unsigned EN_MODE     = EN_OE,
   parameter logic [(2**SEL_W)*RW-1:0] RATIO_TABLE =
      {4'd15, 4'd12, 4'd9, 4'd6, 4'd4, 4'd3, 4'd2, 4'd1}
) (
   input  logic             clk_src,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] fsel,
   input  logic             en_pin,
   output logic             clk_out,
   output logic             ratio_bad
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gf_clkdiv: SYNC_STAGES must be at least 2");
   end
   if (HOLD_CYC < 2) begin : g_bad_hold
      $error("gf_clkdiv: HOLD_CYC must be at least 2");
   end
   if (EN_MODE > EN_PD) begin : g_bad_mode
      $error("gf_clkdiv: EN_MODE must be 0 or 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("gf_clkdiv: SEL_W out of range");
   end

   logic [SEL_W:0]   sync_in;
   logic [SEL_W:0]   sync_out;
   logic [SEL_W-1:0] sel_s;
   logic             en_s;
   logic             pos_q;
   logic             neg_q;
   logic [RW-1:0]    act_ratio;
   logic [RW-1:0]    cnt;
   gfd_state_e       st;

   assign sync_in = {en_pin, fsel};
   assign sel_s   = sync_out[SEL_W-1:0];
   assign en_s    = sync_out[SEL_W];

   gfd_sync #(
      .W      (SEL_W + 1),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk_src),
      .rst_n (rst_n),
      .d     (sync_in),
      .q     (sync_out)
   );

   gfd_ctrl #(
      .SEL_W       (SEL_W),
      .SYNC_STAGES (SYNC_STAGES),
      .HOLD_CYC    (HOLD_CYC),
      .EN_MODE     (EN_MODE),
      .RATIO_TABLE (RATIO_TABLE)
   ) u_ctrl (
      .clk       (clk_src),
      .rst_n     (rst_n),
      .sel_s     (sel_s),
      .en_s      (en_s),
      .pos_q     (pos_q),
      .act_ratio (act_ratio),
      .ratio_bad (ratio_bad),
      .state     (st),
      .cnt       (cnt)
   );

   gfd_outstage u_out (
      .clk       (clk_src),
      .rst_n     (rst_n),
      .pos_q     (pos_q),
      .act_ratio (act_ratio),
      .neg_q     (neg_q),
      .clk_out   (clk_out)
   );

endmodule

// File: rtl/gf_clkdiv_chk.sv
module gf_clkdiv_chk
   import gfd_pkg::*;
#(
   parameter int unsigned EN_MODE = EN_OE
) (
   input logic          clk,
   input logic          rst_n,
   input gfd_state_e    state,
   input logic [RW-1:0] cnt,
   input logic [RW-1:0] act_ratio,
   input logic          ratio_bad,
   input logic          pos_q,
   input logic          neg_q
);

   AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> ratio_legal(act_ratio)); // R1

   AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (cnt < act_ratio)); // R1

   AST_BAD_RUNS_DIV1: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_bad |-> (act_ratio == RW'(1))); // R3

   AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_HOLD) && ($past(state) == ST_RUN))
         |-> (($past(cnt) + 1'b1) == $past(act_ratio))); // R5

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_HOLD) && ($past(state) == ST_HOLD)) |-> (!neg_q && !pos_q)); // R6

   AST_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_RUN) && ($past(state) == ST_HOLD)) |-> (cnt == '0)); // R5

   if (EN_MODE == EN_PD) begin : g_pd_chk
      AST_DOWN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         ((state == ST_DOWN) && ($past(state) == ST_DOWN))
            |-> ($stable(cnt) && !neg_q && !pos_q)); // R9
   end

endmodule

bind gf_clkdiv gf_clkdiv_chk #(
   .EN_MODE (EN_MODE)
) u_chk (
   .clk       (clk_src),
   .rst_n     (rst_n),
   .state     (st),
   .cnt       (cnt),
   .act_ratio (act_ratio),
   .ratio_bad (ratio_bad),
   .pos_q     (pos_q),
   .neg_q     (neg_q)
);

// File: tb/gf_clkdiv_tb.sv
module gf_clkdiv_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = CLK_PERIOD / 2;
   // entry 7 holds the illegal value 7
   localparam logic [31:0] TB_TABLE =
      {4'd7, 4'd15, 4'd9, 4'd6, 4'd4, 4'd3, 4'd2, 4'd1};

   logic       clk    = 1'b0;
   logic       rst_n  = 1'b0;
   logic [2:0] fsel   = 3'd2;
   logic       en_oe  = 1'b1;
   logic       en_pd  = 1'b1;
   logic       out_oe;
   logic       bad_oe;
   logic       out_pd;
   logic       bad_pd;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   gf_clkdiv #(.EN_MODE(0), .RATIO_TABLE(TB_TABLE)) u_dut (
      .clk_src (clk), .rst_n (rst_n), .fsel (fsel), .en_pin (en_oe),
      .clk_out (out_oe), .ratio_bad (bad_oe)
   );

   gf_clkdiv #(.EN_MODE(1), .RATIO_TABLE(TB_TABLE)) u_dut_pd (
      .clk_src (clk), .rst_n (rst_n), .fsel (fsel), .en_pin (en_pd),
      .clk_out (out_pd), .ratio_bad (bad_pd)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   function automatic int exp_ratio(input int code);
      case (code)
         0: return 1;  1: return 2;  2: return 3;  3: return 4;
         4: return 6;  5: return 9;  6: return 15;
         default: return 1;
      endcase
   endfunction

   function automatic bit exp_bad(input int code);
      return (code == 7);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Phase monitor on the output-enable instance
   logic [15:0] allow_mask = 16'h0008;
   int          min_lo     = 3;
   int          cur        = 3;
   longint      last_t, dur, hi_dur, lo_dur, max_lo;
   longint      last_rise, prev_rise;
   int          rise_cnt = 0;
   int          ph;
   bit          have_t = 1'b0;
   bit          ok_hi;

   always @(out_oe) begin
      if (!rst_n) begin
         have_t = 1'b0;
      end else begin
         if (have_t) begin
            dur = longint'($time) - last_t;
            if (out_oe == 1'b0) begin
               hi_dur = dur;
               ph     = int'(dur / HALF);
               ok_hi  = (dur % HALF == 0) && (ph < 16) && allow_mask[ph[3:0]];
               chk(ok_hi, "R5", "high phase length", dur, longint'(cur * HALF));
            end else begin
               lo_dur = dur;
               if (dur > max_lo) max_lo = dur;
               chk(dur >= longint'(min_lo * HALF), "R6", "low phase length",
                   dur, longint'(min_lo * HALF));
            end
         end
         if (out_oe) begin
            prev_rise = last_rise;
            last_rise = longint'($time);
            rise_cnt++;
         end
         last_t = longint'($time);
         have_t = 1'b1;
      end
   end

   // Monitor on the power-down instance
   int     pd_rise_cnt = 0;
   longint pd_t, pd_first;
   bit     pd_arm = 1'b0;

   always @(out_pd) begin
      if (rst_n) begin
         if (out_pd) begin
            pd_rise_cnt++;
            pd_t = longint'($time);
         end else if (pd_rise_cnt > 0 && pd_arm) begin
            pd_first = longint'($time) - pd_t;
            pd_arm   = 1'b0;
         end
      end
   end

   task automatic go(input int code);
      int n;
      n = exp_ratio(code);
      allow_mask[n] = 1'b1;
      if (n < min_lo) min_lo = n;
      fsel = 3'(code);
      cur  = n;
   endtask

   task automatic settle();
      repeat (80) @(negedge clk);
      allow_mask      = '0;
      allow_mask[cur] = 1'b1;
      min_lo          = cur;
      repeat (2 * cur + 4) @(negedge clk);
   endtask

   task automatic steady(input int code);
      chk(hi_dur == longint'(cur * HALF), "R2", "steady high time", hi_dur, longint'(cur * HALF));
      chk(lo_dur == longint'(cur * HALF), "R2", "steady low time", lo_dur, longint'(cur * HALF));
      chk((last_rise - prev_rise) == longint'(cur * CLK_PERIOD), "R1", "output period",
          last_rise - prev_rise, longint'(cur * CLK_PERIOD));
      chk(bad_oe == exp_bad(code), "R3", "ratio_bad flag", longint'(bad_oe),
          longint'(exp_bad(code)));
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   initial begin
      int rc0;
      longint t0;
      void'($urandom(32'd1234));

      // R7: reset state
      repeat (5) @(negedge clk);
      chk(out_oe == 1'b0, "R7", "clk_out in reset", longint'(out_oe), 0);
      chk(bad_oe == 1'b0, "R7", "ratio_bad in reset", longint'(bad_oe), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(out_oe == 1'b0, "R7", "clk_out before sync settles", longint'(out_oe), 0);
      repeat (30) @(negedge clk);
      chk(rise_cnt > 0, "R7", "output started after reset", longint'(rise_cnt), 1);
      settle();
      steady(2);

      // R1 R2 R3: sweep every table entry
      for (int c = 0; c < 8; c++) begin
         go(c);
         settle();
         steady(c);
      end

      // R4: single-cycle select pulse is ignored
      go(3);
      settle();
      max_lo = 0;
      fsel = 3'd6;
      @(negedge clk);
      fsel = 3'd3;
      repeat (60) @(negedge clk);
      chk(max_lo == longint'(4 * HALF), "R4", "longest low after pulse", max_lo,
          longint'(4 * HALF));
      steady(3);

      // R5 R6: random select changes, some during pending switches
      for (int i = 0; i < 24; i++) begin
         go(int'($urandom % 8));
         repeat (int'($urandom % 50) + 1) @(negedge clk);
      end
      settle();
      steady(int'(fsel));

      // R8: output enable mode keeps the period grid
      go(5);
      settle();
      steady(5);
      t0 = last_rise;
      en_oe = 1'b0;
      repeat (30) @(negedge clk);
      rc0 = rise_cnt;
      repeat (60) @(negedge clk);
      chk(rise_cnt == rc0, "R8", "rising edges while disabled", longint'(rise_cnt - rc0), 0);
      chk(out_oe == 1'b0, "R8", "clk_out while disabled", longint'(out_oe), 0);
      en_oe = 1'b1;
      repeat (60) @(negedge clk);
      chk(rise_cnt > rc0, "R8", "output resumed", longint'(rise_cnt - rc0), 1);
      chk(((last_rise - t0) % longint'(9 * CLK_PERIOD)) == 0, "R8", "edge grid offset",
          (last_rise - t0) % longint'(9 * CLK_PERIOD), 0);

      // R9: power-down mode freezes and restarts cleanly
      en_pd = 1'b0;
      repeat (30) @(negedge clk);
      rc0 = pd_rise_cnt;
      repeat (60) @(negedge clk);
      chk(pd_rise_cnt == rc0, "R9", "edges while powered down", longint'(pd_rise_cnt - rc0), 0);
      chk(out_pd == 1'b0, "R9", "clk_out while powered down", longint'(out_pd), 0);
      pd_arm = 1'b1;
      en_pd  = 1'b1;
      repeat (60) @(negedge clk);
      chk(pd_rise_cnt > rc0, "R9", "output resumed", longint'(pd_rise_cnt - rc0), 1);
      chk(pd_first == longint'(9 * HALF), "R9", "first high after restart", pd_first,
          longint'(9 * HALF));

      done = 1'b1;
      finish_up();
   end

endmodule